// File: doc/BRIEF.md
# Two-Pass Memory Device Tester

This engine proves that every bit in a range of memory words can store both a zero and a one. It is started once the data-bus and address-bus wiring checks have already succeeded, because its verdict means nothing on a broken bus. It walks a range given by a start address and a word count, both captured when `start` is accepted. It then runs two passes over that range. Each pass first writes the whole range, and only then reads it all back and compares.

In the first pass, word *i* of the range receives the value *i + 1*, counted modulo 2^DATA_W. In the second pass, every word receives the bitwise inverse of its first-pass value, so each cell is driven to both states. Writing the whole range before any read means a read never lands right after a write to the same word. Because the values differ from word to word, leftover charge on a floating data bus cannot pass for stored data. The engine stops at the first word that compares wrong. It holds that word's address, the value it expected and the value it got, and reports done with pass low. If nothing compares wrong, it reports done with pass high after the second pass.

The memory port is a simple single-request master. A write completes in its request cycle. Read data is taken exactly READ_LATENCY cycles after the read request, and no new request is issued until that read is compared.

Top module: `mem_device_tester`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `test_done`, `test_pass` and `mem_req` are all 0 until a start is accepted.
- R2: `start` is accepted only when `busy` is 0; it captures `range_base` and `range_words` and raises `busy` from the next cycle. A `start` pulse while busy has no effect on the running test.
- R3: In pass one, the engine writes word *i* (i = 0 .. N-1) at address (`range_base` + i) mod 2^ADDR_W, in ascending order, one write per cycle, with data (i + 1) mod 2^DATA_W.
- R4: All N writes of a pass are issued before its first read. Reads then run in ascending address order, so for N ≥ 2 no read addresses the word written in the request just before it.
- R5: Pass two writes the bitwise complement of each word's pass-one value and verifies it the same way.
- R6: A read request lasts one cycle. `mem_rdata` is compared in the cycle READ_LATENCY cycles after the request cycle, and no request is issued in between.
- R7: At the first mismatch the engine issues no further request. It sets `test_done`=1 and `test_pass`=0, and holds `fail_addr`, `fail_expected` and `fail_actual` until the next start.
- R8: When every read matches, `test_done`=1 and `test_pass`=1 after pass two, after exactly 4·N memory requests.
- R9: A start with `range_words` = 0 gives `test_done`=1 and `test_pass`=1 in the next cycle with no memory request.
- R10: For ranges longer than 2^DATA_W words, the pattern wraps: word 2^DATA_W receives pass-one value 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test when idle |
| range_base | input | ADDR_W | First address of the range |
| range_words | input | ADDR_W+1 | Number of words to test |
| busy | output | 1 | Test in progress |
| test_done | output | 1 | Test finished; held until next start |
| test_pass | output | 1 | Valid with test_done: 1 = no mismatch |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid READ_LATENCY cycles after a read request |
| fail_addr | output | ADDR_W | Address of first mismatch |
| fail_expected | output | DATA_W | Value expected there |
| fail_actual | output | DATA_W | Value read there |

## Verification
The memory model attached to the engine can inject five conditions: a healthy array, a cell stuck at 0, a cell stuck at 1, an absent device whose reads return the last value written on the bus, and an address bit that is ignored so that words alias. Stuck cells are placed so that one is caught in pass one and another escapes pass one and is caught only by the complemented pass. This separates the two passes. The absent-device and aliasing cases show that verifying after the full fill catches what a write-then-read scheme would miss. Counting the requests per run tells a clean finish (4·N) apart from an early stop at the first bad word. Further runs cover a range that wraps the address space, one longer than the pattern period, an empty range and a start pulse during a run.

// File: rtl/mt_pkg.sv
// Shared types for the memory device tester.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_RREQ  = 2'd2,
        ST_RWAIT = 2'd3
    } tester_state_e;
endpackage

// File: rtl/mt_index_seq.sv
// Range walker: holds the captured base and word count, and steps an
// index through 0 .. count-1. Assumes advance is never asked for on the
// last word (the controller rewinds instead).
module mt_index_seq #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              advance,
    input  logic              rewind,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  idx,
    output logic              last
);
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  idx_q;

    // Capture the range on load; step or rewind the word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            count_q <= '0;
            idx_q   <= '0;
        end else if (load) begin
            base_q  <= base_in;
            count_q <= count_in;
            idx_q   <= '0;
        end else if (rewind) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= idx_q + CNT_W'(1);
        end
    end

    // Address wraps modulo the address space; last marks the final word.
    always_comb begin
        addr = base_q + idx_q[ADDR_W-1:0];
        idx  = idx_q;
        last = (idx_q == (count_q - CNT_W'(1)));
    end

    // R3: the walker never steps beyond the final word of the range
    a_r3_no_step_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !last);
endmodule

// File: rtl/mt_pattern_gen.sv
// Test pattern source: word index i maps to (i+1) mod 2^DATA_W, inverted
// in the second pass. Purely combinational; assumes idx is stable.
module mt_pattern_gen #(
    parameter int IDX_W  = 17,
    parameter int DATA_W = 16
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              invert,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] seq_val;

    // Incrementing value, truncated to the data width, optionally inverted.
    always_comb begin
        seq_val = DATA_W'(idx) + DATA_W'(1);
        data    = invert ? ~seq_val : seq_val;
    end
endmodule

// File: rtl/mt_read_timer.sv
// Read latency timer: counts the cycles spent waiting for read data and
// flags the cycle in which mem_rdata is to be sampled. Assumes
// READ_LATENCY >= 1 and that in_wait stays high until hit.
module mt_read_timer #(
    parameter int READ_LATENCY = 1,
    localparam int TW = $clog2(READ_LATENCY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_wait,
    output logic hit
);
    logic [TW-1:0] cnt_q;

    // Count wait cycles; restart whenever the controller is not waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_wait) cnt_q <= '0;
        else                    cnt_q <= cnt_q + TW'(1);
    end

    // Sample point is READ_LATENCY cycles after the request cycle.
    always_comb hit = in_wait && (cnt_q == TW'(READ_LATENCY - 1));

    // R6: the wait never runs past its sample point
    a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/mt_fail_capture.sv
// Mismatch record: holds the address, expected and actual data of the
// first failing word. Assumes capture fires at most once per test.
module mt_fail_capture #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] exp_in,
    input  logic [DATA_W-1:0] act_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] exp_q,
    output logic [DATA_W-1:0] act_q
);
    // Clear on a new test, latch on the first mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr_q <= '0;
            exp_q  <= '0;
            act_q  <= '0;
        end else if (capture) begin
            addr_q <= addr_in;
            exp_q  <= exp_in;
            act_q  <= act_in;
        end
    end
endmodule

// File: rtl/mem_device_tester.sv
// Two-pass memory device tester. Pass one fills the range with an
// incrementing value, then verifies it; pass two does the same with the
// complement. Stops at the first mismatch. Assumes the data and address
// buses were already proven, writes finish in their request cycle and
// read data arrives READ_LATENCY cycles after a read request.
module mem_device_tester #(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int READ_LATENCY = 1,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] range_base,
    input  logic [CNT_W-1:0]  range_words,
    output logic              busy,
    output logic              test_done,
    output logic              test_pass,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_expected,
    output logic [DATA_W-1:0] fail_actual
);
    import mt_pkg::*;

    tester_state_e     st_q;
    logic              phase_q;
    logic              done_q;
    logic              pass_q;
    logic              accept;
    logic              advance;
    logic              rewind;
    logic              hit;
    logic              mismatch;
    logic              last;
    logic [CNT_W-1:0]  idx;
    logic [ADDR_W-1:0] word_addr;
    logic [DATA_W-1:0] pattern;

    mt_index_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .base_in(range_base), .count_in(range_words),
        .advance(advance), .rewind(rewind),
        .addr(word_addr), .idx(idx), .last(last)
    );

    mt_pattern_gen #(.IDX_W(CNT_W), .DATA_W(DATA_W)) u_pat (
        .idx(idx), .invert(phase_q), .data(pattern)
    );

    mt_read_timer #(.READ_LATENCY(READ_LATENCY)) u_timer (
        .clk(clk), .rst_n(rst_n), .in_wait(st_q == ST_RWAIT), .hit(hit)
    );

    mt_fail_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear(accept), .capture(mismatch),
        .addr_in(word_addr), .exp_in(pattern), .act_in(mem_rdata),
        .addr_q(fail_addr), .exp_q(fail_expected), .act_q(fail_actual)
    );

    // Sequencing strobes derived from the current state and compare result.
    always_comb begin
        accept   = (st_q == ST_IDLE) && start;
        mismatch = hit && (mem_rdata != pattern);
        advance  = ((st_q == ST_WRITE) && !last) ||
                   (hit && !mismatch && !last);
        rewind   = ((st_q == ST_WRITE) && last) ||
                   (hit && !mismatch && last && !phase_q);
    end

    // Memory master port driven straight from the state and the walker.
    always_comb begin
        mem_req   = (st_q == ST_WRITE) || (st_q == ST_RREQ);
        mem_we    = (st_q == ST_WRITE);
        mem_addr  = word_addr;
        mem_wdata = pattern;
        busy      = (st_q != ST_IDLE);
        test_done = done_q;
        test_pass = pass_q;
    end

    // Controller: fill, then verify word by word, for each of two passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            phase_q <= 1'b0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        phase_q <= 1'b0;
                        done_q  <= (range_words == '0);
                        pass_q  <= (range_words == '0);
                        st_q    <= (range_words == '0) ? ST_IDLE : ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (last) st_q <= ST_RREQ;
                end
                ST_RREQ: begin
                    st_q <= ST_RWAIT;
                end
                ST_RWAIT: begin
                    if (hit) begin
                        if (mismatch) begin
                            done_q <= 1'b1;
                            pass_q <= 1'b0;
                            st_q   <= ST_IDLE;
                        end else if (!last) begin
                            st_q <= ST_RREQ;
                        end else if (!phase_q) begin
                            phase_q <= 1'b1;
                            st_q    <= ST_WRITE;
                        end else begin
                            done_q <= 1'b1;
                            pass_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R3: back-to-back writes step the address by exactly one word
    a_r3_write_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we))
            |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    // R6: a read request is followed by at least one idle cycle
    a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);

    // R7: a finished test issues no memory traffic
    a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |-> !mem_req);

    // R7: the mismatch record stays put until a new start
    a_r7_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (test_done && !test_pass && !start) |=> $stable(fail_addr) && $stable(fail_actual));

    // R9: an empty range reports success one cycle after start
    a_r9_empty_range: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && range_words == '0) |=> (test_done && test_pass));
endmodule

// File: tb/mem_device_tester_test.sv
`timescale 1ns/1ps
module mem_device_tester_test;
    localparam int AW  = 6;
    localparam int DW  = 4;
    localparam int LAT = 2;
    localparam int CW  = AW + 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [AW-1:0] range_base;
    logic [CW-1:0] range_words;
    logic          busy, test_done, test_pass;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_expected, fail_actual;

    always #2.5 clk = ~clk;

    mem_device_tester #(.ADDR_W(AW), .DATA_W(DW), .READ_LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .range_base(range_base), .range_words(range_words),
        .busy(busy), .test_done(test_done), .test_pass(test_pass),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .fail_addr(fail_addr), .fail_expected(fail_expected),
        .fail_actual(fail_actual)
    );

    // Memory model with injectable faults:
    // 0 healthy, 1 cell bit stuck at 0, 2 cell bit stuck at 1,
    // 3 absent device (reads return last bus write), 4 address bit ignored.
    logic [DW-1:0] mem [0:(1<<AW)-1];
    logic [DW-1:0] last_w = '0, pipe0 = '0, pipe1 = '0;
    int fault_kind = 0, fault_addr = 0, fault_bit = 0;

    function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
        if (fault_kind == 4) return a & ~(AW'(1) << fault_bit);
        return a;
    endfunction

    function automatic logic [DW-1:0] read_val(input logic [AW-1:0] a);
        logic [DW-1:0] v;
        v = mem[phys(a)];
        if (fault_kind == 1 && int'(phys(a)) == fault_addr) v = v & ~(DW'(1) << fault_bit);
        if (fault_kind == 2 && int'(phys(a)) == fault_addr) v = v | (DW'(1) << fault_bit);
        if (fault_kind == 3) v = last_w;
        return v;
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[phys(mem_addr)] <= mem_wdata;
            last_w <= mem_wdata;
        end
        pipe0 <= (mem_req && !mem_we) ? read_val(mem_addr) : '0;
        pipe1 <= pipe0;
    end
    assign mem_rdata = pipe1;

    // Bus monitor: request count and read-right-after-own-write detector.
    int txn = 0, viol = 0;
    logic          prev_w = 1'b0;
    logic [AW-1:0] prev_a = '0;
    always @(posedge clk) begin
        if (rst_n && mem_req) txn++;
        if (rst_n && mem_req && !mem_we && prev_w && mem_addr == prev_a) viol++;
        prev_w = mem_req && mem_we;
        prev_a = mem_addr;
    end

    int checks = 0, fails = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic launch(input logic [AW-1:0] b, input logic [CW-1:0] w);
        @(negedge clk);
        range_base = b; range_words = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!test_done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (!test_done) chk("watchdog R8", 0, 1);
    endtask

    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] words;
        logic [2:0]    kind;
        logic [AW-1:0] faddr;
        logic [1:0]    fbit;
        logic          exp_pass;
        logic [AW-1:0] exp_addr;
        logic [DW-1:0] exp_e;
        logic [DW-1:0] exp_a;
        logic [8:0]    exp_txn;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{6'd5,  7'd10, 3'd0, 6'd0,  2'd0, 1'b1, 6'd0,  4'd0,  4'd0,  9'd40},
        '{6'd0,  7'd20, 3'd0, 6'd0,  2'd0, 1'b1, 6'd0,  4'd0,  4'd0,  9'd80},
        '{6'd10, 7'd8,  3'd1, 6'd12, 2'd0, 1'b0, 6'd12, 4'd3,  4'd2,  9'd11},
        '{6'd10, 7'd8,  3'd1, 6'd11, 2'd0, 1'b0, 6'd11, 4'hD,  4'hC,  9'd26},
        '{6'd16, 7'd8,  3'd2, 6'd20, 2'd3, 1'b0, 6'd20, 4'd5,  4'hD,  9'd13},
        '{6'd0,  7'd6,  3'd3, 6'd0,  2'd0, 1'b0, 6'd0,  4'd1,  4'd6,  9'd7},
        '{6'd0,  7'd16, 3'd4, 6'd0,  2'd3, 1'b0, 6'd0,  4'd1,  4'd9,  9'd17},
        '{6'd60, 7'd8,  3'd0, 6'd0,  2'd0, 1'b1, 6'd0,  4'd0,  4'd0,  9'd32},
        '{6'd0,  7'd64, 3'd0, 6'd0,  2'd0, 1'b1, 6'd0,  4'd0,  4'd0,  9'd256}
    };

    initial begin
        rst_n = 1'b0; start = 1'b0; range_base = '0; range_words = '0;
        repeat (3) @(negedge clk);
        // R1: quiet under reset
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(test_done), 0);
        chk("R1 pass", int'(test_pass), 0);
        chk("R1 mem_req", int'(mem_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", int'(busy || mem_req || test_done), 0);

        // Vector table: fault scenarios and healthy ranges.
        for (int i = 0; i < NV; i++) begin
            int t0, v0;
            fault_kind = int'(VECS[i].kind);
            fault_addr = int'(VECS[i].faddr);
            fault_bit  = int'(VECS[i].fbit);
            t0 = txn; v0 = viol;
            launch(VECS[i].base, VECS[i].words);
            chk("R2 busy after start", int'(busy), 1);
            wait_done();
            chk("R7/R8 done", int'(test_done), 1);
            chk("R7/R8 pass flag", int'(test_pass), int'(VECS[i].exp_pass));
            chk("R6/R7/R8 request count", txn - t0, int'(VECS[i].exp_txn));
            chk("R4 no read after own write", viol - v0, 0);
            if (!VECS[i].exp_pass) begin
                chk("R7 fail_addr", int'(fail_addr), int'(VECS[i].exp_addr));
                chk("R3/R5 fail_expected", int'(fail_expected), int'(VECS[i].exp_e));
                chk("R6 fail_actual", int'(fail_actual), int'(VECS[i].exp_a));
                repeat (3) @(negedge clk);
                chk("R7 no traffic after stop", txn - t0, int'(VECS[i].exp_txn));
                chk("R7 record held", int'(fail_addr), int'(VECS[i].exp_addr));
            end
            if (i == 1) begin
                // R10: word 16 got pattern 1 (complemented 0xE), word 15 got 0 (0xF)
                chk("R10 wrap word 16", int'(mem[16]), 14);
                chk("R10 word 15", int'(mem[15]), 15);
            end
        end

        // R9: empty range
        fault_kind = 0;
        begin
            int t0;
            t0 = txn;
            launch(6'd3, 7'd0);
            chk("R9 done", int'(test_done), 1);
            chk("R9 pass", int'(test_pass), 1);
            chk("R9 busy", int'(busy), 0);
            repeat (3) @(negedge clk);
            chk("R9 no requests", txn - t0, 0);
        end

        // R2: start while busy is ignored
        begin
            int t0;
            t0 = txn;
            launch(6'd5, 7'd10);
            repeat (4) @(negedge clk);
            range_base = 6'd0; range_words = 7'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done();
            chk("R2 pass despite extra start", int'(test_pass), 1);
            chk("R2 request count unchanged", txn - t0, 40);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule